// File: doc/BRIEF.md
# Static Physical Memory Attribute Checker

This block sits between a core's instruction-fetch and load/store units and the memory system. It classifies each physical address against three independent rule tables: I/O (reads have side effects), executable and cacheable. It then decides whether each request may go out. The rule tables are elaboration-time parameters. Each table gives a count of active rules and, for every rule, a base address and a length. Nothing in the tables can change while the chip runs.

A fetch is forwarded only to code space. Any other fetch is swallowed and reported through a one-cycle access-fault pulse that carries the offending address. A speculative load aimed at I/O space is held, with its ready low, until the core signals that the load is the oldest committed operation. A flush that arrives while the load is held drops it. Addresses that match no rule are still forwarded, and errors on empty address space are left to the bus response. The block produces no coherence, atomicity or reservation attribute, and every access is treated as non-coherent.

Top module: `pma_checker`

## Requirements
- R1: Each attribute vector `if_attr` / `ls_attr` is encoded as bit 0 = I/O (non-idempotent), bit 1 = executable, bit 2 = cacheable. A bit is 1 exactly when the port's address satisfies base <= addr < base + length (unsigned) for at least one active rule of that class. The three classes are evaluated independently, and overlapping rules in one class are ORed.
- R2: A rule whose length is zero never matches, and rules whose index is at or above the class's active count are ignored.
- R3: Attribute outputs follow the request address combinationally, in the same cycle.
- R4: A fetch is forwarded (`if_mem_valid` = `if_req_valid`, `if_req_ready` = `if_mem_ready`) only when its address is executable and not I/O.
- R5: A denied fetch is not forwarded, and `if_req_ready` is 1 whatever `if_mem_ready` is. On the next cycle, `if_fault_valid` is 1 for one cycle and `if_fault_addr` holds the denied address.
- R6: A load that is not speculative, or any load or store outside I/O space, is forwarded in the same cycle with its address and write flag. This includes addresses that match no rule, and `ls_req_ready` follows `ls_mem_ready`.
- R7: A speculative load (`ls_req_we` = 0, `ls_req_spec` = 1) to I/O space while `ls_commit` is 0 is not forwarded, and `ls_req_ready` stays 0.
- R8: Such a load is forwarded in the first cycle in which `ls_commit` is 1. This holds whether that is the arrival cycle or a later one.
- R9: A held load is dropped when `ls_flush` is 1. It is not forwarded in the flush cycle, even if `ls_commit` is also 1.
- R10: A speculative store to I/O space is forwarded without waiting for `ls_commit`.
- R11: After synchronous reset, `if_fault_valid` is 0 and the load/store path holds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| if_req_valid | input | 1 | Fetch request valid |
| if_req_addr | input | ADDR_W | Fetch physical address |
| if_req_ready | output | 1 | Fetch request accepted or consumed |
| if_attr | output | 3 | Fetch address attributes {cacheable, executable, I/O} |
| if_mem_valid | output | 1 | Fetch forwarded to memory |
| if_mem_addr | output | ADDR_W | Forwarded fetch address |
| if_mem_ready | input | 1 | Memory accepts fetch |
| if_fault_valid | output | 1 | Instruction access-fault pulse |
| if_fault_addr | output | ADDR_W | Address of the denied fetch |
| ls_req_valid | input | 1 | Load/store request valid |
| ls_req_addr | input | ADDR_W | Load/store physical address |
| ls_req_we | input | 1 | 1 = store, 0 = load |
| ls_req_spec | input | 1 | Request is speculative |
| ls_commit | input | 1 | Request is the oldest, committed operation |
| ls_flush | input | 1 | Pipeline flush |
| ls_req_ready | output | 1 | Load/store request accepted |
| ls_attr | output | 3 | Load/store address attributes {cacheable, executable, I/O} |
| ls_mem_valid | output | 1 | Load/store forwarded to memory |
| ls_mem_addr | output | ADDR_W | Forwarded load/store address |
| ls_mem_we | output | 1 | Forwarded write flag |
| ls_mem_ready | input | 1 | Memory accepts load/store |

## Verification
The bench probes each region edge: the first address, the last address and the address one past the end. A design using <= on the upper bound, or computing base + length in a way that overflows, would misclassify these edges; a rule ending at the top of the address space is included to expose the overflow case. It also probes a zero-length rule, a rule beyond the active count, and executable space that overlaps I/O space. A checker that honoured disabled rules would report attributes for unmapped space. One that checked only the executable bit would fetch from I/O space. For the speculative-load path, the bench holds a load across several cycles and then releases it with commit. It raises flush together with commit, where a careless design would forward the dropped load. It also sends a speculative store to I/O, which must not stall.

// File: rtl/pma_pkg.sv
package pma_pkg;

    // Widest address the range helper handles
    localparam int unsigned PMA_CMP_W = 64;

    typedef struct packed {
        logic cache;    // bit 2
        logic exec;     // bit 1
        logic io;       // bit 0
    } pma_attr_t;

    typedef enum logic {
        LS_IDLE        = 1'b0,
        LS_WAIT_COMMIT = 1'b1
    } ls_state_e;

    // Unsigned half-open range test; subtracting first avoids base+len overflow
    function automatic logic in_range(
        input logic [PMA_CMP_W-1:0] addr,
        input logic [PMA_CMP_W-1:0] base,
        input logic [PMA_CMP_W-1:0] len
    );
        logic [PMA_CMP_W-1:0] off;
        off = addr - base;
        return (len != '0) && (addr >= base) && (off < len);
    endfunction

endpackage

// File: rtl/pma_region_match.sv
module pma_region_match #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_RULES = 4,
    parameter int unsigned NUM_RULES = 1,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] BASE = '0,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] LEN  = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int unsigned PAD_W = pma_pkg::PMA_CMP_W - ADDR_W;

    logic [MAX_RULES-1:0] rule_hit;

    for (genvar i = 0; i < MAX_RULES; i++) begin : g_rule
        if (i < NUM_RULES) begin : g_active
            assign rule_hit[i] = pma_pkg::in_range({{PAD_W{1'b0}}, addr},
                                                   {{PAD_W{1'b0}}, BASE[i]},
                                                   {{PAD_W{1'b0}}, LEN[i]});
        end else begin : g_off
            assign rule_hit[i] = 1'b0;
        end
    end

    assign hit = |rule_hit;

endmodule

// File: rtl/pma_classifier.sv
module pma_classifier #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_RULES = 4,
    parameter int unsigned IO_N      = 1,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_BASE = '0,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_LEN  = '0,
    parameter int unsigned EX_N      = 1,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EX_BASE = '0,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EX_LEN  = '0,
    parameter int unsigned CA_N      = 1,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CA_BASE = '0,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CA_LEN  = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output pma_pkg::pma_attr_t attr
);
    logic io_hit, ex_hit, ca_hit;

    pma_region_match #(.ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .NUM_RULES(IO_N),
                       .BASE(IO_BASE), .LEN(IO_LEN))
        u_io (.addr(addr), .hit(io_hit));

    pma_region_match #(.ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .NUM_RULES(EX_N),
                       .BASE(EX_BASE), .LEN(EX_LEN))
        u_ex (.addr(addr), .hit(ex_hit));

    pma_region_match #(.ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES), .NUM_RULES(CA_N),
                       .BASE(CA_BASE), .LEN(CA_LEN))
        u_ca (.addr(addr), .hit(ca_hit));

    always_comb begin
        attr       = '0;
        attr.io    = io_hit;
        attr.exec  = ex_hit;
        attr.cache = ca_hit;
    end

endmodule

// File: rtl/pma_fetch_gate.sv
module pma_fetch_gate #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    input  logic              is_exec,
    input  logic              is_io,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_addr
);
    logic allowed;
    logic deny;

    // Fetch is inherently speculative, so I/O space is never a fetch target
    assign allowed   = is_exec && !is_io;
    assign deny      = req_valid && !allowed;
    assign mem_valid = req_valid && allowed;
    assign req_ready = allowed ? mem_ready : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_valid <= 1'b0;
            fault_addr  <= '0;
        end else begin
            fault_valid <= deny;
            if (deny) begin
                fault_addr <= req_addr;
            end
        end
    end

    // R4: forwarding implies code space outside I/O
    a_r4_fetch_only_code: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (is_exec && !is_io));

    // R5: a fault follows a request that was not forwarded, with its address
    a_r5_fault_follows_deny: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !mem_valid) |=> (fault_valid && fault_addr == $past(req_addr)));

    // R5: forwarded requests never fault
    a_r5_no_fault_on_fwd: assert property (@(posedge clk) disable iff (rst)
        mem_valid |=> !fault_valid);

endmodule

// File: rtl/pma_ls_gate.sv
module pma_ls_gate (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_we,
    input  logic req_spec,
    input  logic is_io,
    input  logic commit,
    input  logic flush,
    output logic req_ready,
    output logic mem_valid,
    input  logic mem_ready
);
    import pma_pkg::*;

    ls_state_e state_q, state_d;
    logic      hold_cls;   // request belongs to the must-wait class
    logic      pass_ok;    // gate open this cycle (independent of valid)

    assign hold_cls = !req_we && req_spec && is_io;

    always_comb begin
        if (hold_cls || state_q == LS_WAIT_COMMIT) begin
            pass_ok = hold_cls ? (commit && !flush) : !flush;
        end else begin
            pass_ok = 1'b1;
        end
    end

    assign mem_valid = req_valid && pass_ok;
    assign req_ready = pass_ok && mem_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE: begin
                if (req_valid && hold_cls && !flush && !(mem_valid && mem_ready)) begin
                    state_d = LS_WAIT_COMMIT;
                end
            end
            LS_WAIT_COMMIT: begin
                if (flush || !req_valid || (mem_valid && mem_ready)) begin
                    state_d = LS_IDLE;
                end
            end
            default: state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // R7: while waiting, nothing goes out without commit
    a_r7_wait_needs_commit: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_WAIT_COMMIT && hold_cls && !commit) |-> !mem_valid && !req_ready);

    // R8: acceptance only together with a memory handshake
    a_r8_ready_is_handshake: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |-> (mem_valid && mem_ready));

    // R9: a flush always leaves nothing held
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> state_q == LS_IDLE);

    // R9: a held load is never released in a flush cycle
    a_r9_no_release_on_flush: assert property (@(posedge clk) disable iff (rst)
        (flush && hold_cls) |-> !mem_valid);

endmodule

// File: rtl/pma_checker.sv
module pma_checker #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned MAX_RULES = 4,
    parameter int unsigned IO_N      = 2,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_BASE =
        {32'h0000_0000, 32'h0000_0000, 32'hFFFF_F000, 32'h1000_0000},
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] IO_LEN =
        {32'h0000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0000_1000},
    parameter int unsigned EX_N      = 4,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EX_BASE =
        {32'h2000_0000, 32'h1000_0000, 32'h0001_0000, 32'h8000_0000},
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] EX_LEN =
        {32'h0000_0000, 32'h0000_0100, 32'h0001_0000, 32'h4000_0000},
    parameter int unsigned CA_N      = 2,
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CA_BASE =
        {32'h0000_0000, 32'h0001_0000, 32'h8000_0000, 32'h8000_0000},
    parameter logic [MAX_RULES-1:0][ADDR_W-1:0] CA_LEN =
        {32'h0000_0000, 32'h0001_0000, 32'h0000_1000, 32'h4000_0000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              if_req_valid,
    input  logic [ADDR_W-1:0] if_req_addr,
    output logic              if_req_ready,
    output logic [2:0]        if_attr,
    output logic              if_mem_valid,
    output logic [ADDR_W-1:0] if_mem_addr,
    input  logic              if_mem_ready,
    output logic              if_fault_valid,
    output logic [ADDR_W-1:0] if_fault_addr,
    input  logic              ls_req_valid,
    input  logic [ADDR_W-1:0] ls_req_addr,
    input  logic              ls_req_we,
    input  logic              ls_req_spec,
    input  logic              ls_commit,
    input  logic              ls_flush,
    output logic              ls_req_ready,
    output logic [2:0]        ls_attr,
    output logic              ls_mem_valid,
    output logic [ADDR_W-1:0] ls_mem_addr,
    output logic              ls_mem_we,
    input  logic              ls_mem_ready
);
    import pma_pkg::*;

    pma_attr_t if_cls, ls_cls;

    pma_classifier #(
        .ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES),
        .IO_N(IO_N), .IO_BASE(IO_BASE), .IO_LEN(IO_LEN),
        .EX_N(EX_N), .EX_BASE(EX_BASE), .EX_LEN(EX_LEN),
        .CA_N(CA_N), .CA_BASE(CA_BASE), .CA_LEN(CA_LEN)
    ) u_if_cls (.addr(if_req_addr), .attr(if_cls));

    pma_classifier #(
        .ADDR_W(ADDR_W), .MAX_RULES(MAX_RULES),
        .IO_N(IO_N), .IO_BASE(IO_BASE), .IO_LEN(IO_LEN),
        .EX_N(EX_N), .EX_BASE(EX_BASE), .EX_LEN(EX_LEN),
        .CA_N(CA_N), .CA_BASE(CA_BASE), .CA_LEN(CA_LEN)
    ) u_ls_cls (.addr(ls_req_addr), .attr(ls_cls));

    pma_fetch_gate #(.ADDR_W(ADDR_W)) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (if_req_valid),
        .req_addr   (if_req_addr),
        .req_ready  (if_req_ready),
        .is_exec    (if_cls.exec),
        .is_io      (if_cls.io),
        .mem_valid  (if_mem_valid),
        .mem_ready  (if_mem_ready),
        .fault_valid(if_fault_valid),
        .fault_addr (if_fault_addr)
    );

    pma_ls_gate u_ls (
        .clk      (clk),
        .rst      (rst),
        .req_valid(ls_req_valid),
        .req_we   (ls_req_we),
        .req_spec (ls_req_spec),
        .is_io    (ls_cls.io),
        .commit   (ls_commit),
        .flush    (ls_flush),
        .req_ready(ls_req_ready),
        .mem_valid(ls_mem_valid),
        .mem_ready(ls_mem_ready)
    );

    assign if_attr     = if_cls;
    assign ls_attr     = ls_cls;
    assign if_mem_addr = if_req_addr;
    assign ls_mem_addr = ls_req_addr;
    assign ls_mem_we   = ls_req_we;

    // R6: a request outside the must-wait class is never stalled by the gate
    a_r6_plain_passes: assert property (@(posedge clk) disable iff (rst)
        (ls_req_valid && !(ls_req_spec && !ls_req_we && ls_attr[0]) && !ls_flush)
            |-> ls_mem_valid);

    // R10: speculative stores to I/O do not wait for commit
    a_r10_store_no_wait: assert property (@(posedge clk) disable iff (rst)
        (ls_req_valid && ls_req_we && !ls_flush) |-> ls_mem_valid);

endmodule

// File: tb/tb_pma_checker.sv
module tb_pma_checker;

    localparam int unsigned AW     = 32;
    localparam int unsigned NVEC   = 17;
    localparam int unsigned WDOG   = 5000;

    // {address, expected attr {cache, exec, io}}
    localparam logic [NVEC-1:0][34:0] VEC = {
        {32'h8000_0800, 3'b110},
        {32'hFFFF_EFFF, 3'b000},
        {32'hFFFF_F000, 3'b001},
        {32'hFFFF_FFFF, 3'b001},
        {32'h2000_0000, 3'b000},
        {32'h1000_1000, 3'b000},
        {32'h1000_0FFF, 3'b001},
        {32'h1000_0100, 3'b001},
        {32'h1000_00FF, 3'b011},
        {32'h1000_0000, 3'b011},
        {32'h0002_0000, 3'b000},
        {32'h0001_FFFF, 3'b010},
        {32'h0001_0000, 3'b010},
        {32'h7FFF_FFFF, 3'b000},
        {32'hC000_0000, 3'b000},
        {32'hBFFF_FFFF, 3'b110},
        {32'h8000_0000, 3'b110}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          if_req_valid, if_req_ready, if_mem_valid, if_mem_ready, if_fault_valid;
    logic [AW-1:0] if_req_addr, if_mem_addr, if_fault_addr;
    logic [2:0]    if_attr, ls_attr;
    logic          ls_req_valid, ls_req_we, ls_req_spec, ls_commit, ls_flush, ls_req_ready;
    logic          ls_mem_valid, ls_mem_we, ls_mem_ready;
    logic [AW-1:0] ls_req_addr, ls_mem_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pma_checker dut (
        .clk(clk), .rst(rst),
        .if_req_valid(if_req_valid), .if_req_addr(if_req_addr), .if_req_ready(if_req_ready),
        .if_attr(if_attr), .if_mem_valid(if_mem_valid), .if_mem_addr(if_mem_addr),
        .if_mem_ready(if_mem_ready), .if_fault_valid(if_fault_valid),
        .if_fault_addr(if_fault_addr),
        .ls_req_valid(ls_req_valid), .ls_req_addr(ls_req_addr), .ls_req_we(ls_req_we),
        .ls_req_spec(ls_req_spec), .ls_commit(ls_commit), .ls_flush(ls_flush),
        .ls_req_ready(ls_req_ready), .ls_attr(ls_attr), .ls_mem_valid(ls_mem_valid),
        .ls_mem_addr(ls_mem_addr), .ls_mem_we(ls_mem_we), .ls_mem_ready(ls_mem_ready)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ls_drive(input logic v, input logic [AW-1:0] a, input logic we,
                            input logic spec, input logic cm, input logic fl);
        ls_req_valid = v; ls_req_addr = a; ls_req_we = we;
        ls_req_spec = spec; ls_commit = cm; ls_flush = fl;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        if_req_valid = 1'b0; if_req_addr = '0; if_mem_ready = 1'b1;
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        ls_mem_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check("R11 fault after reset", {63'b0, if_fault_valid}, 64'd0);
        ls_drive(1'b1, 32'h1000_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check("R11 nothing held after reset", {63'b0, ls_mem_valid}, 64'd1);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // Vector walk: R1 R2 R3 classification, R4 R5 fetch gating, R6 plain forward
        for (int i = 0; i < NVEC; i++) begin
            logic [AW-1:0] a;
            logic [2:0]    ex;
            logic          ok;
            @(negedge clk);
            a  = VEC[i][34:3];
            ex = VEC[i][2:0];
            ok = ex[1] && !ex[0];
            if_req_valid = 1'b1; if_req_addr = a;
            ls_drive(1'b1, a, 1'b0, 1'b0, 1'b0, 1'b0);
            #1;
            check($sformatf("R1 R2 R3 if_attr @%h", a), {61'b0, if_attr}, {61'b0, ex});
            check($sformatf("R1 ls_attr @%h", a), {61'b0, ls_attr}, {61'b0, ex});
            check($sformatf("R4 if_mem_valid @%h", a), {63'b0, if_mem_valid}, {63'b0, ok});
            check($sformatf("R4 if_mem_addr @%h", a), {32'b0, if_mem_addr}, {32'b0, a});
            check($sformatf("R6 ls forwarded @%h", a), {63'b0, ls_mem_valid}, 64'd1);
            @(posedge clk);
            #1;
            check($sformatf("R5 fault pulse @%h", a), {63'b0, if_fault_valid}, {63'b0, !ok});
            if (!ok) begin
                check($sformatf("R5 fault addr @%h", a), {32'b0, if_fault_addr}, {32'b0, a});
            end
        end
        @(negedge clk);
        if_req_valid = 1'b0;
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk); #1;
        check("R5 fault lasts one cycle", {63'b0, if_fault_valid}, 64'd0);

        // R5: denied fetch consumed even when memory stalls; R4 allowed fetch follows ready
        @(negedge clk);
        if_mem_ready = 1'b0; if_req_valid = 1'b1; if_req_addr = 32'h1000_0000;
        #1;
        check("R5 denied fetch ready", {63'b0, if_req_ready}, 64'd1);
        if_req_addr = 32'h8000_0000;
        #1;
        check("R4 allowed fetch ready follows mem", {63'b0, if_req_ready}, 64'd0);
        @(negedge clk);
        if_req_valid = 1'b0; if_mem_ready = 1'b1;

        // R6: stall from memory propagates to requester
        ls_mem_ready = 1'b0;
        ls_drive(1'b1, 32'h0500_0000, 1'b0, 1'b1, 1'b0, 1'b0);
        #1;
        check("R6 ready follows mem ready", {63'b0, ls_req_ready}, 64'd0);
        check("R6 unmapped still forwarded", {63'b0, ls_mem_valid}, 64'd1);
        ls_mem_ready = 1'b1;
        @(negedge clk);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7 / R8: hold then release on commit
        @(negedge clk);
        ls_drive(1'b1, 32'h1000_0010, 1'b0, 1'b1, 1'b0, 1'b0);
        #1;
        check("R7 held on arrival", {63'b0, ls_mem_valid}, 64'd0);
        check("R7 ready low on arrival", {63'b0, ls_req_ready}, 64'd0);
        repeat (2) begin
            @(negedge clk); #1;
            check("R7 still held", {63'b0, ls_mem_valid}, 64'd0);
        end
        @(negedge clk);
        ls_commit = 1'b1;
        #1;
        check("R8 released on commit", {63'b0, ls_mem_valid}, 64'd1);
        check("R8 ready on commit", {63'b0, ls_req_ready}, 64'd1);
        check("R8 address forwarded", {32'b0, ls_mem_addr}, {32'b0, 32'h1000_0010});
        @(negedge clk);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R8: commit already present on arrival
        @(negedge clk);
        ls_drive(1'b1, 32'hFFFF_F100, 1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        check("R8 same-cycle commit", {63'b0, ls_mem_valid}, 64'd1);
        @(negedge clk);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: flush drops held load even with commit
        @(negedge clk);
        ls_drive(1'b1, 32'h1000_0020, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        ls_commit = 1'b1; ls_flush = 1'b1;
        #1;
        check("R9 no release on flush", {63'b0, ls_mem_valid}, 64'd0);
        check("R9 no ready on flush", {63'b0, ls_req_ready}, 64'd0);
        @(negedge clk);
        ls_drive(1'b1, 32'h0800_0000, 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        check("R9 path free after flush", {63'b0, ls_mem_valid}, 64'd1);
        @(negedge clk);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R10: speculative store to I/O is not held
        @(negedge clk);
        ls_drive(1'b1, 32'h1000_0040, 1'b1, 1'b1, 1'b0, 1'b0);
        #1;
        check("R10 spec store forwarded", {63'b0, ls_mem_valid}, 64'd1);
        check("R10 write flag", {63'b0, ls_mem_we}, 64'd1);
        @(negedge clk);
        ls_drive(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule